// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block holds the interrupt state of an I2C master controller. The bus engine reports five kinds of events as single-cycle pulses. They are a finished transaction, a missing acknowledge on address or data, a refused high-speed master code, a lost arbitration and the end of one transfer in an auto-restart sequence. Each event is latched into its own status bit. Software reads and clears those bits through a small register port that shares the engine's clock. A mask register selects which pending bits drive the single level-sensitive interrupt line.

A failed transaction must reach software as two separate interrupts. When the engine reports completion in the same cycle as an acknowledge error, or while an acknowledge-class error is still pending, the completion is held back. It is posted only once software has cleared every acknowledge-class error bit. The interrupt line therefore drops for at least one cycle between the error interrupt and the completion interrupt.

Top module: `i2c_irq_status`

## Requirements
- R1: A synchronous active-high reset clears all status bits, all mask bits, `reg_rdata` and `irq`.
- R2: An event pulse sets its status bit at the next clock edge, and the bit stays set until software clears it. The bit positions are: bit 0 transaction done, bit 1 acknowledge error, bit 2 high-speed master-code NACK, bit 3 arbitration lost, bit 4 restart done.
- R3: A write with `reg_sel`=0 clears each status bit whose `reg_wdata` bit is 1 and leaves the others unchanged. Writing back the value just read clears exactly the bits that were read as set.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: A write with `reg_sel`=1 loads mask bits 4..0 from `reg_wdata[4:0]`. Bits 15..5 of both registers always read 0, and writes to those positions have no effect.
- R6: Status bits latch whether or not they are masked. `irq` is 1 exactly one cycle after some status bit and its mask bit are both 1, so unmasking a pending bit raises `irq`.
- R7: A done event that arrives in the same cycle as an acknowledge or high-speed NACK error, or while either of those bits is set, does not set bit 0 right away. Bit 0 is set one cycle after both error bits read clear, so `irq` drops for at least one cycle between the two interrupts.
- R8: `reg_rdata` is registered. After each clock edge it shows the register chosen by `reg_sel`, as it stood just before that edge (`reg_sel`=0 status, 1 mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of the bus engine and the register port |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | 1 | Transaction finished pulse |
| evt_ack_err | input | 1 | Address or data not acknowledged pulse |
| evt_hs_nack | input | 1 | High-speed master code not acknowledged pulse |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_restart | input | 1 | One transfer of an auto-restart sequence finished pulse |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data of the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded properties check several behaviours on every cycle. An event sets its bit, a clearing write without a competing event drops the bit, and a bit never changes without an event or a clear. A mask write lands as written. A held completion stays held while an error bit is pending. The completion bit never rises while an acknowledge-class error bit is set, and the interrupt line follows the masked status one cycle later. Other behaviours need the bench's scenarios to show. These are that writing back a read value clears exactly those bits, that upper bit positions stay zero, and that unmasking raises a pending request. They also include that the interrupt line visibly drops between the error and completion interrupts, and that a reset in the middle of a run returns every register to zero.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned EVT_N   = 5;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned B_DONE  = 0;
  localparam int unsigned B_ACKE  = 1;
  localparam int unsigned B_HSNK  = 2;
  localparam int unsigned B_ARBL  = 3;
  localparam int unsigned B_RSTD  = 4;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/isu_status_bank.sv
module isu_status_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  // one sticky flag per event; a set beats a clear in the same cycle
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           stat_o[g] <= 1'b0;
      else if (set_i[g]) stat_o[g] <= 1'b1;
      else if (clr_i[g]) stat_o[g] <= 1'b0;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> stat_o[g]); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !stat_o[g]); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
      (!set_i[g] && !clr_i[g]) |=> $stable(stat_o[g])); // R2
  end
endmodule

// File: rtl/isu_done_seq.sv
module isu_done_seq (
  input  logic clk,
  input  logic rst,
  input  logic done_evt_i,
  input  logic err_evt_i,
  input  logic err_held_i,
  output logic done_set_o
);
  logic pend_q;
  logic blocked;

  always_comb begin
    blocked    = err_evt_i | err_held_i;
    done_set_o = (done_evt_i | pend_q) & ~blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (done_evt_i | pend_q) & blocked;
  end

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && err_held_i) |=> pend_q); // R7

  AST_DONE_DEFER: assert property (@(posedge clk) disable iff (rst)
    (done_evt_i && err_evt_i) |-> !done_set_o); // R7
endmodule

// File: rtl/isu_regport.sv
module isu_regport #(
  parameter int unsigned DW = 16,
  parameter int unsigned N  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [N-1:0]  stat_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] reg_rdata
);
  import isu_pkg::*;

  localparam int unsigned PAD_W = DW - N;

  logic wr_stat;
  logic wr_mask;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DW-1:N];

  always_comb begin
    wr_stat = reg_wr && (reg_sel_e'(reg_sel) == SEL_STATUS);
    wr_mask = reg_wr && (reg_sel_e'(reg_sel) == SEL_MASK);
    clr_o   = wr_stat ? reg_wdata[N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_o <= '0;
    else if (wr_mask) mask_o <= reg_wdata[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                                      reg_rdata <= '0;
    else if (reg_sel_e'(reg_sel) == SEL_MASK)     reg_rdata <= {{PAD_W{1'b0}}, mask_o};
    else                                          reg_rdata <= {{PAD_W{1'b0}}, stat_i};
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_o == $past(reg_wdata[N-1:0]))); // R5

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_o)); // R5
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int unsigned DW = isu_pkg::REG_W,
  parameter int unsigned N  = isu_pkg::EVT_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_done,
  input  logic          evt_ack_err,
  input  logic          evt_hs_nack,
  input  logic          evt_arb_lost,
  input  logic          evt_restart,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  import isu_pkg::*;

  logic [N-1:0] stat;
  logic [N-1:0] mask;
  logic [N-1:0] clr;
  logic [N-1:0] set_vec;
  logic         done_set;
  logic         err_evt;
  logic         err_held;

  always_comb begin
    err_evt  = evt_ack_err | evt_hs_nack;
    err_held = stat[B_ACKE] | stat[B_HSNK];
    set_vec          = '0;
    set_vec[B_DONE]  = done_set;
    set_vec[B_ACKE]  = evt_ack_err;
    set_vec[B_HSNK]  = evt_hs_nack;
    set_vec[B_ARBL]  = evt_arb_lost;
    set_vec[B_RSTD]  = evt_restart;
  end

  isu_done_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .done_evt_i (evt_done),
    .err_evt_i  (err_evt),
    .err_held_i (err_held),
    .done_set_o (done_set)
  );

  isu_status_bank #(.N(N)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .clr_i  (clr),
    .stat_o (stat)
  );

  isu_regport #(.DW(DW), .N(N)) u_port (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .stat_i    (stat),
    .mask_o    (mask),
    .clr_o     (clr),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & mask);
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(stat & mask)) |=> irq); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & mask)) |=> !irq); // R6

  AST_DONE_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[B_DONE]) |-> !stat[B_ACKE] && !stat[B_HSNK]); // R7
endmodule

// File: tb/tb_i2c_irq_status.sv
module tb_i2c_irq_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  evt = '0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  i2c_irq_status dut (
    .clk          (clk),
    .rst          (rst),
    .evt_done     (evt[0]),
    .evt_ack_err  (evt[1]),
    .evt_hs_nack  (evt[2]),
    .evt_arb_lost (evt[3]),
    .evt_restart  (evt[4]),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq          (irq)
  );

  // fields: evt[32:28] wr[27] sel[26] wdata[25:10] exp_stat[9:5] exp_mask[4:0]
  localparam int NV = 15;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {5'b00001, 1'b0, 1'b0, 16'h0000, 5'b00001, 5'b00000},
    {5'b00000, 1'b1, 1'b1, 16'hFFFF, 5'b00001, 5'b11111},
    {5'b11000, 1'b0, 1'b0, 16'h0000, 5'b11001, 5'b11111},
    {5'b00000, 1'b1, 1'b0, 16'h0009, 5'b10000, 5'b11111},
    {5'b00001, 1'b1, 1'b0, 16'h0001, 5'b10001, 5'b11111},
    {5'b00000, 1'b1, 1'b0, 16'hFFE0, 5'b10001, 5'b11111},
    {5'b00000, 1'b1, 1'b0, 16'hFFF1, 5'b00000, 5'b11111},
    {5'b00011, 1'b0, 1'b0, 16'h0000, 5'b00010, 5'b11111},
    {5'b00000, 1'b1, 1'b0, 16'h0002, 5'b00001, 5'b11111},
    {5'b00100, 1'b0, 1'b0, 16'h0000, 5'b00101, 5'b11111},
    {5'b00000, 1'b1, 1'b0, 16'h0005, 5'b00000, 5'b11111},
    {5'b00000, 1'b1, 1'b1, 16'h0006, 5'b00000, 5'b00110},
    {5'b00010, 1'b0, 1'b0, 16'h0000, 5'b00010, 5'b00110},
    {5'b00001, 1'b0, 1'b0, 16'h0000, 5'b00010, 5'b00110},
    {5'b00000, 1'b1, 1'b0, 16'h0002, 5'b00001, 5'b00110}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 2, 9:   return "R2";
      1:         return "R5";
      3, 6, 10:  return "R3";
      4:         return "R4";
      5:         return "R5";
      7, 8:      return "R7";
      11, 12:    return "R6";
      default:   return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // called at a negedge; applies one cycle of stimulus, returns at next negedge
  task automatic step(input logic [4:0] e, input logic w, input logic s,
                      input logic [15:0] d);
    evt = e; reg_wr = w; reg_sel = s; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    evt = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic s, output logic [15:0] v);
    reg_sel = s;
    @(posedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {15'd0, irq}, 16'h0000);
    chk(reg_rdata == 16'h0000, "R1 rdata", reg_rdata, 16'h0000);
    rd(1'b1, v);
    chk(v == 16'h0000, "R1 mask", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] t;
      logic [15:0] es, em;
      t = VEC[i];
      es = {11'd0, t[9:5]};
      em = {11'd0, t[4:0]};
      step(t[32:28], t[27], t[26], t[25:10]);
      step(5'b0, 1'b0, 1'b0, 16'h0000);
      rd(1'b0, v);  // R8 registered read of status
      chk(v == es, {vec_tag(i), " status"}, v, es);
      rd(1'b1, v);
      chk(v == em, {vec_tag(i), " mask"}, v, em);
      chk(irq == |(t[9:5] & t[4:0]), {vec_tag(i), " irq R6"}, {15'd0, irq},
          {15'd0, |(t[9:5] & t[4:0])});
    end

    // R6: masked bit still latches, unmasking raises irq
    step(5'b0, 1'b1, 1'b0, 16'hFFFF);
    step(5'b0, 1'b1, 1'b1, 16'h0000);
    step(5'b01000, 1'b0, 1'b0, 16'h0000);
    step(5'b0, 1'b0, 1'b0, 16'h0000);
    chk(irq == 1'b0, "R6 masked irq", {15'd0, irq}, 16'h0000);
    rd(1'b0, v);
    chk(v == 16'h0008, "R6 latched while masked", v, 16'h0008);
    step(5'b0, 1'b1, 1'b1, 16'h0008);
    step(5'b0, 1'b0, 1'b0, 16'h0000);
    chk(irq == 1'b1, "R6 unmask raises irq", {15'd0, irq}, 16'h0001);

    // R7: irq drops between the error interrupt and the completion interrupt
    step(5'b0, 1'b1, 1'b0, 16'hFFFF);
    step(5'b0, 1'b1, 1'b1, 16'h001F);
    step(5'b00011, 1'b0, 1'b0, 16'h0000);
    step(5'b0, 1'b0, 1'b0, 16'h0000);
    chk(irq == 1'b1, "R7 error irq", {15'd0, irq}, 16'h0001);
    step(5'b0, 1'b1, 1'b0, 16'h0002);
    step(5'b0, 1'b0, 1'b0, 16'h0000);
    chk(irq == 1'b0, "R7 irq gap", {15'd0, irq}, 16'h0000);
    step(5'b0, 1'b0, 1'b0, 16'h0000);
    chk(irq == 1'b1, "R7 done irq", {15'd0, irq}, 16'h0001);
    rd(1'b0, v);
    chk(v == 16'h0001, "R7 done posted", v, 16'h0001);

    // R1: reset mid-run clears everything
    rst = 1'b1;
    step(5'b0, 1'b0, 1'b0, 16'h0000);
    rst = 1'b0;
    chk(irq == 1'b0, "R1 irq after reset", {15'd0, irq}, 16'h0000);
    rd(1'b0, v);
    chk(v == 16'h0000, "R1 status after reset", v, 16'h0000);
    rd(1'b1, v);
    chk(v == 16'h0000, "R1 mask after reset", v, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule